// File: doc/BRIEF.md
# Banked Serial-Port Host Register Bank

This block is the host-facing register bank of a simplified byte-oriented serial port. A host reaches eight byte registers through a 3-bit offset with single-cycle read and write strobes. Bit 7 of the line control register selects a second bank. With that bit set, offsets 0 and 1 address the two bytes of a 16-bit divisor. With it clear, they carry transmit/receive data and the interrupt enable register.

Bytes arriving on the receive input are stored in a parameterised-depth circular queue, and host reads of offset 0 drain it. Host writes of data bytes leave the block as a one-cycle transmit strobe with the byte beside it. The line status register always reports the transmitter as empty. The interrupt identification register flips its low bit on every read. An interrupt pulse marks each accepted receive byte while receive interrupts are enabled.

Top module: `sport_regfile`

## Requirements
- R1: After reset, host_rdata, tx_strobe, irq_pulse and fifo_ctrl are 0. The line control, interrupt enable, modem control, scratch and divisor registers are 0, the identification register holds 0x01, and the receive queue is empty.
- R2: While line-control bit 7 is 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. A write to offset 0 in this bank raises no transmit strobe, and a read of offset 0 removes nothing from the receive queue.
- R3: While line-control bit 7 is 0, a write to offset 0 raises tx_strobe for exactly one cycle on the cycle after the write strobe, with tx_data equal to the written byte. A written value of 0xFF raises no strobe.
- R4: While line-control bit 7 is 0, a read of offset 0 returns the oldest queued receive byte and removes it, so bytes come out in arrival order. A read of offset 0 with the queue empty returns 0xFF and leaves the queue unchanged.
- R5: While line-control bit 7 is 0, offset 1 is the interrupt enable register, readable and writable as a full byte.
- R6: A receive byte accepted into the queue raises irq_pulse for one cycle on the following cycle if interrupt-enable bit 0 was 1 on the cycle the byte arrived. Otherwise no pulse is raised.
- R7: A read of offset 5 returns line status. Bit 0 is 1 when the queue holds at least one byte, bits 5 and 6 are always 1, and all other bits are 0.
- R8: A read of offset 2 returns the identification register and then inverts its bit 0. A write to offset 2 loads fifo_ctrl and leaves the identification register unchanged.
- R9: Offsets 3 (line control), 4 (modem control) and 7 (scratch) read back the last byte written to them.
- R10: Writes to offsets 5 and 6 change no register. A read of offset 6 returns 0x00.
- R11: A receive byte that arrives while the queue holds DEPTH bytes is dropped, and the queued contents are kept.
- R12: host_rdata changes only on the clock edge that samples a read strobe. It then holds the register value as it stood before that edge until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Single-cycle read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data, valid the cycle after host_rd |
| rx_valid | input | 1 | Receive byte present this cycle |
| rx_data | input | 8 | Receive byte |
| tx_strobe | output | 1 | One-cycle transmit byte strobe |
| tx_data | output | 8 | Transmit byte, valid with tx_strobe |
| irq_pulse | output | 1 | One-cycle receive interrupt pulse |
| fifo_ctrl | output | 8 | Last byte written to offset 2 |

## Verification
The assertions check on every cycle the properties that can be stated locally. A transmit strobe never carries 0xFF and is always caused by a data-bank write to offset 0. An interrupt pulse is always preceded by a receive byte. The queue occupancy never exceeds DEPTH. Line-status reads always show the transmitter as empty with the ready bit matching occupancy. Empty data reads return 0xFF, and a divisor-bank read of offset 0 never drains the queue. Only the bench's scenarios against its reference model can show the rest: arrival order across a full queue with the overflow bytes dropped, the exact divisor bytes, the identification bit alternating across successive reads, and the ignored writes to offsets 5 and 6.

// File: rtl/sport_pkg.sv
package sport_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
   localparam logic [ADDR_W-1:0] OFS_IEN   = 3'd1;
   localparam logic [ADDR_W-1:0] OFS_IDENT = 3'd2;
   localparam logic [ADDR_W-1:0] OFS_LCTL  = 3'd3;
   localparam logic [ADDR_W-1:0] OFS_MCTL  = 3'd4;
   localparam logic [ADDR_W-1:0] OFS_LSTAT = 3'd5;
   localparam logic [ADDR_W-1:0] OFS_MSTAT = 3'd6;
   localparam logic [ADDR_W-1:0] OFS_SCR   = 3'd7;

   localparam int unsigned BANK_BIT = 7;
   localparam logic [BYTE_W-1:0] IDENT_RST = 8'h01;
   localparam logic [BYTE_W-1:0] TX_DROP   = 8'hFF;
   localparam logic [BYTE_W-1:0] EMPTY_RD  = 8'hFF;
   localparam logic [BYTE_W-1:0] MSTAT_VAL = 8'h00;

   typedef struct packed {
      logic [BYTE_W-1:0]   lctl;
      logic [BYTE_W-1:0]   ien;
      logic [BYTE_W-1:0]   mctl;
      logic [BYTE_W-1:0]   fctl;
      logic [BYTE_W-1:0]   scr;
      logic [BYTE_W-1:0]   ident;
      logic [2*BYTE_W-1:0] divisor;
   } sport_regs_t;
endpackage

// File: rtl/sport_rxq.sv
module sport_rxq #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned W     = 8,
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] count
);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
   localparam logic [CW-1:0] CAP  = CW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sport_rxq: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CAP);
   assign count   = cnt_q;
   assign head    = mem[rd_ptr];
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_cmp_wrap
      assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/sport_regbank.sv
module sport_regbank
   import sport_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              q_empty,
   input  logic [BYTE_W-1:0] q_head,
   output logic              q_pop,
   output logic              tx_req,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              bank_div,
   output logic              rx_irq_en,
   output logic [BYTE_W-1:0] fctl,
   output logic [BYTE_W-1:0] rdata
);
   sport_regs_t       r;
   logic [BYTE_W-1:0] rd_mux;
   logic [BYTE_W-1:0] lstat;

   assign bank_div  = r.lctl[BANK_BIT];
   assign rx_irq_en = r.ien[0];
   assign fctl      = r.fctl;
   assign tx_byte   = wdata;
   assign tx_req    = wr && (addr == OFS_DATA) && !bank_div && (wdata != TX_DROP);
   assign q_pop     = rd && (addr == OFS_DATA) && !bank_div && !q_empty;
   assign lstat     = {1'b0, 1'b1, 1'b1, 4'b0000, !q_empty};

   always_comb begin
      unique case (addr)
         OFS_DATA:  rd_mux = bank_div ? r.divisor[BYTE_W-1:0]
                                      : (q_empty ? EMPTY_RD : q_head);
         OFS_IEN:   rd_mux = bank_div ? r.divisor[2*BYTE_W-1:BYTE_W] : r.ien;
         OFS_IDENT: rd_mux = r.ident;
         OFS_LCTL:  rd_mux = r.lctl;
         OFS_MCTL:  rd_mux = r.mctl;
         OFS_LSTAT: rd_mux = lstat;
         OFS_MSTAT: rd_mux = MSTAT_VAL;
         default:   rd_mux = r.scr;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r       <= '0;
         r.ident <= IDENT_RST;
         rdata   <= '0;
      end else begin
         if (rd) begin
            rdata <= rd_mux;
            if (addr == OFS_IDENT) r.ident <= r.ident ^ 8'h01;
         end
         if (wr) begin
            unique case (addr)
               OFS_DATA:  if (bank_div) r.divisor[BYTE_W-1:0] <= wdata;
               OFS_IEN:   if (bank_div) r.divisor[2*BYTE_W-1:BYTE_W] <= wdata;
                          else          r.ien <= wdata;
               OFS_IDENT: r.fctl <= wdata;
               OFS_LCTL:  r.lctl <= wdata;
               OFS_MCTL:  r.mctl <= wdata;
               OFS_SCR:   r.scr  <= wdata;
               default:   ;
            endcase
         end
      end
   end
endmodule

// File: rtl/sport_events.sv
module sport_events
   import sport_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_req,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              rx_accept,
   input  logic              rx_irq_en,
   output logic              tx_strobe,
   output logic [BYTE_W-1:0] tx_data,
   output logic              irq_pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_strobe <= 1'b0;
         tx_data   <= '0;
         irq_pulse <= 1'b0;
      end else begin
         tx_strobe <= tx_req;
         if (tx_req) tx_data <= tx_byte;
         irq_pulse <= rx_accept && rx_irq_en;
      end
   end
endmodule

// File: rtl/sport_regfile.sv
module sport_regfile #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] host_addr,
   input  logic       host_wr,
   input  logic       host_rd,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   output logic       tx_strobe,
   output logic [7:0] tx_data,
   output logic       irq_pulse,
   output logic [7:0] fifo_ctrl
);
   logic          q_empty, q_full, q_pop, tx_req, dlab, rx_irq_en, rx_accept;
   logic [7:0]    q_head, tx_byte;
   logic [CW-1:0] q_count;

   assign rx_accept = rx_valid && !q_full;

   sport_rxq #(.DEPTH(DEPTH), .W(8)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_valid), .push_data(rx_data),
      .pop(q_pop), .head(q_head), .empty(q_empty), .full(q_full),
      .count(q_count)
   );

   sport_regbank u_regs (
      .clk(clk), .rst_n(rst_n), .addr(host_addr), .wr(host_wr),
      .rd(host_rd), .wdata(host_wdata), .q_empty(q_empty), .q_head(q_head),
      .q_pop(q_pop), .tx_req(tx_req), .tx_byte(tx_byte), .bank_div(dlab),
      .rx_irq_en(rx_irq_en), .fctl(fifo_ctrl), .rdata(host_rdata)
   );

   sport_events u_evt (
      .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_byte(tx_byte),
      .rx_accept(rx_accept), .rx_irq_en(rx_irq_en), .tx_strobe(tx_strobe),
      .tx_data(tx_data), .irq_pulse(irq_pulse)
   );
endmodule

// File: rtl/sport_regfile_chk.sv
module sport_regfile_chk #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    host_addr,
   input logic          host_wr,
   input logic          host_rd,
   input logic [7:0]    host_rdata,
   input logic          rx_valid,
   input logic          tx_strobe,
   input logic [7:0]    tx_data,
   input logic          irq_pulse,
   input logic          dlab,
   input logic [CW-1:0] q_count
);
   assert_no_ff_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_strobe |-> tx_data != 8'hFF);

   assert_tx_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_strobe |-> ($past(host_wr) && $past(host_addr) == 3'd0 && !$past(dlab)));

   assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(rx_valid));

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(DEPTH));

   assert_lstat_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(host_rd) && $past(host_addr) == 3'd5) |->
      (host_rdata[6:5] == 2'b11 && host_rdata[0] == ($past(q_count) != '0)));

   assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(host_rd) && $past(host_addr) == 3'd0 && !$past(dlab) &&
       $past(q_count) == '0) |-> host_rdata == 8'hFF);

   assert_div_no_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == 3'd0 && dlab && !rx_valid) |=> $stable(q_count));
endmodule

bind sport_regfile sport_regfile_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
   .host_rd(host_rd), .host_rdata(host_rdata), .rx_valid(rx_valid),
   .tx_strobe(tx_strobe), .tx_data(tx_data), .irq_pulse(irq_pulse),
   .dlab(dlab), .q_count(q_count)
);

// File: tb/sport_regfile_tb.sv
module sport_regfile_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] host_addr = '0;
   logic       host_wr = 1'b0, host_rd = 1'b0, rx_valid = 1'b0;
   logic [7:0] host_wdata = '0, rx_data = '0;
   logic [7:0] host_rdata, tx_data, fifo_ctrl;
   logic       tx_strobe, irq_pulse;

   int    vectors = 0;
   int    fails = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   sport_regfile #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .tx_strobe(tx_strobe),
      .tx_data(tx_data), .irq_pulse(irq_pulse), .fifo_ctrl(fifo_ctrl)
   );

   // Behavioural reference model
   logic [7:0]  m_q[$];
   logic [7:0]  m_lctl, m_ien, m_mctl, m_fctl, m_scr, m_ident;
   logic [15:0] m_div;
   logic [7:0]  e_rdata, e_txd;
   logic        e_tx, e_irq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q.delete();
         {m_lctl, m_ien, m_mctl, m_fctl, m_scr} = '0;
         m_ident = 8'h01; m_div = '0;
         e_rdata = '0; e_txd = '0; e_tx = 1'b0; e_irq = 1'b0;
      end else begin
         automatic int  pre_n   = m_q.size();
         automatic bit  bank    = m_lctl[7];
         automatic bit  ien0    = m_ien[0];
         e_tx = 1'b0; e_irq = 1'b0;
         if (host_rd) begin
            case (host_addr)
               3'd0: if (bank) e_rdata = m_div[7:0];
                     else if (m_q.size() == 0) e_rdata = 8'hFF;
                     else e_rdata = m_q.pop_front();
               3'd1: e_rdata = bank ? m_div[15:8] : m_ien;
               3'd2: begin e_rdata = m_ident; m_ident[0] = ~m_ident[0]; end
               3'd3: e_rdata = m_lctl;
               3'd4: e_rdata = m_mctl;
               3'd5: e_rdata = {1'b0, 2'b11, 4'b0, pre_n != 0};
               3'd6: e_rdata = 8'h00;
               default: e_rdata = m_scr;
            endcase
         end
         if (host_wr) begin
            case (host_addr)
               3'd0: if (bank) m_div[7:0] = host_wdata;
                     else if (host_wdata != 8'hFF) begin
                        e_tx = 1'b1; e_txd = host_wdata;
                     end
               3'd1: if (bank) m_div[15:8] = host_wdata; else m_ien = host_wdata;
               3'd2: m_fctl = host_wdata;
               3'd3: m_lctl = host_wdata;
               3'd4: m_mctl = host_wdata;
               3'd7: m_scr = host_wdata;
               default: ;
            endcase
         end
         if (rx_valid && pre_n < DEPTH) begin
            m_q.push_back(rx_data);
            e_irq = ien0;
         end
      end
   end

   task automatic fail_line(string what, logic [7:0] act, logic [7:0] exp);
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h t=%0t", cur_req, what, act, exp, $time);
   endtask

   // Compared on every falling edge: R12 (registered read data) applies to all
   always @(negedge clk) begin
      if (e_rdata !== 8'hxx) begin
         vectors++;
         if (host_rdata !== e_rdata) fail_line("host_rdata(R12)", host_rdata, e_rdata);
         if (tx_strobe !== e_tx) fail_line("tx_strobe", {7'd0, tx_strobe}, {7'd0, e_tx});
         if (e_tx && tx_data !== e_txd) fail_line("tx_data", tx_data, e_txd);
         if (irq_pulse !== e_irq) fail_line("irq_pulse", {7'd0, irq_pulse}, {7'd0, e_irq});
         if (fifo_ctrl !== m_fctl) fail_line("fifo_ctrl", fifo_ctrl, m_fctl);
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk); host_wr = 1'b0;
   endtask
   task automatic rd(input logic [2:0] a);
      host_addr = a; host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0;
   endtask
   task automatic rx(input logic [7:0] d);
      rx_data = d; rx_valid = 1'b1;
      @(negedge clk); rx_valid = 1'b0;
   endtask
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic finish_run;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R12 actual=running expected=done");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      cur_req = "R1";  rd(3'd2); rd(3'd3); rd(3'd1); rd(3'd5); idle(1);
      cur_req = "R9";  wr(3'd3, 8'h03); rd(3'd3); wr(3'd4, 8'h1B); rd(3'd4);
                       wr(3'd7, 8'hA5); rd(3'd7); wr(3'd7, 8'h5A); rd(3'd7);
      cur_req = "R5";  wr(3'd1, 8'hF1); rd(3'd1); wr(3'd1, 8'h01); rd(3'd1);
      cur_req = "R3";  wr(3'd0, 8'h41); idle(1); wr(3'd0, 8'hFF); idle(1);
                       wr(3'd0, 8'h0A); wr(3'd0, 8'h00); idle(2);
      cur_req = "R6";  rx(8'h11); idle(1); rx(8'h22); rx(8'h33);
      cur_req = "R7";  rd(3'd5);
      cur_req = "R2";  wr(3'd3, 8'h83); wr(3'd0, 8'h34); wr(3'd1, 8'h12);
                       rd(3'd0); rd(3'd1); wr(3'd0, 8'h55); idle(1); rd(3'd0);
                       rd(3'd5); wr(3'd3, 8'h03); rd(3'd1);
      cur_req = "R4";  rd(3'd0); rd(3'd0); rd(3'd0); rd(3'd0); rd(3'd0);
      cur_req = "R7";  rd(3'd5);
      cur_req = "R6";  wr(3'd1, 8'h00); rx(8'h44); idle(1); rd(3'd0);
      cur_req = "R8";  rd(3'd2); rd(3'd2); wr(3'd2, 8'hC7); rd(3'd2); rd(3'd2);
                       wr(3'd2, 8'h01); rd(3'd2);
      cur_req = "R10"; wr(3'd5, 8'hFF); wr(3'd6, 8'h77); rd(3'd6); rd(3'd5);
                       rd(3'd3); rd(3'd7); rd(3'd4);
      cur_req = "R11"; wr(3'd1, 8'h01);
      for (int i = 0; i < DEPTH + 3; i++) rx(8'(i + 8'h80));
      rd(3'd5);
      for (int i = 0; i < DEPTH; i++) rd(3'd0);
      rd(3'd0); rd(3'd5);
      cur_req = "R4";  rx(8'h9C); rd(3'd0); rd(3'd0);
      idle(3);
      finish_run();
   end
endmodule